// File: doc/BRIEF.md
# Channel Enable and Suspend Control Registers

This block is the register bank that starts, stops, pauses and resumes the channels of a multi-channel DMA controller. Every control bit has a companion write-enable bit in the same word. A write changes a control bit only where its companion is 1, so software can switch one channel on or off without a read-modify-write of the other channels. The per-channel enable and suspend bits drive the channel engines directly.

The channel count is a parameter from 1 to 16, and it fixes the register layout at elaboration. With eight channels or fewer, one 32-bit word at offset 0x018 carries enable and suspend control. With more than eight, the word at 0x018 carries only enable control, and suspend control moves to a separate word at 0x020. When a channel engine acknowledges a suspend request, the block sets a sticky per-channel "halted" flag. Software polls this flag at offset 0x024 to learn that the pause has completed. The flag also drives an output port.

Reads are combinational from the address. Writes take effect at the rising clock edge that samples the strobe.

Top module: `dma_chan_ctl_regs`

## Requirements
- R1: Synchronous active-low reset clears every enable bit, suspend bit and halted flag, so all outputs and all three readable words read 0.
- R2: A channel count of 8 or less selects the compact layout. A count of 9 to 16 selects the wide layout.
- R3: Compact layout, word 0x018: enable values in bits [7:0], enable write-enables in [15:8], suspend values in [23:16], suspend write-enables in [31:24]. Bit position within each field equals the channel number.
- R4: Wide layout: word 0x018 holds enable values in [15:0] and enable write-enables in [31:16]. Word 0x020 holds suspend values in [15:0] and suspend write-enables in [31:16].
- R5: A control bit whose write-enable bit is 0 in a write keeps its value. Writes to unmapped offsets change nothing.
- R6: Write-enable bit positions always read back as 0.
- R7: In the compact layout, offset 0x020 reads as 0 and writes to it change nothing.
- R8: Bits for channels at or above the configured count read as 0 and ignore writes, in every word including the status word.
- R9: A channel's suspend bit is 0 whenever its enable bit is 0 after a write. Clearing an enable bit also clears its suspend bit, even in the same write that sets suspend.
- R10: A halted flag sets at the clock edge that samples that channel's suspend acknowledge while its suspend bit is 1. The flags read at 0x024 bits [N-1:0], and they never set without that acknowledge.
- R11: A halted flag stays set until the channel's suspend bit becomes 0, through a resume or a disable, and it clears at that same edge.
- R12: The enable, suspend and halted outputs equal the stored bits, so a write is visible on them in the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| susp_ack | input | NUM_CH | Suspend acknowledge from each channel engine |
| chan_en | output | NUM_CH | Channel enable controls |
| chan_susp | output | NUM_CH | Channel suspend requests |
| chan_halted | output | NUM_CH | Sticky suspended status flags |

## Verification
Read data depends only on the address and the stored state, so a readback is due in the same cycle the address is presented. A write or an acknowledge lands at the rising edge that samples it and is visible on the outputs and on readback one cycle later. The bench drives every input just after a falling edge and samples all results one time unit later, before the next rising edge. It advances its own model only at that rising edge, so each comparison sees the state left by the previous cycle. Two instances, with four and with twelve channels, receive the same bus traffic, which covers both layouts.

// File: rtl/chan_ctl_pkg.sv
// Shared constants for the channel control register bank.
// Assumes byte offsets fit in 12 bits; the top casts them to its address width.
package chan_ctl_pkg;
    localparam logic [11:0] OFS_CTRL    = 12'h018;  // enable (and compact suspend) word
    localparam logic [11:0] OFS_SUSP    = 12'h020;  // wide-layout suspend word
    localparam logic [11:0] OFS_STAT    = 12'h024;  // halted status word
    localparam int          COMPACT_MAX = 8;        // largest count using one word
    localparam int          MAX_CH      = 16;
    localparam int          REG_W       = 32;
endpackage

// File: rtl/chan_ctl_wdec.sv
// Write decoder: turns a register write into per-channel value/write-enable
// pairs for enable and suspend. Layout chosen at elaboration by NUM_CH.
// Assumes 1 <= NUM_CH <= 16 and a single-cycle write strobe.
module chan_ctl_wdec
    import chan_ctl_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 12
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [NUM_CH-1:0] en_we,
    output logic [NUM_CH-1:0] en_wd,
    output logic [NUM_CH-1:0] su_we,
    output logic [NUM_CH-1:0] su_wd
);
    localparam bit COMPACT  = (NUM_CH <= COMPACT_MAX);
    localparam int LANE     = COMPACT ? 8 : 16;
    localparam int EN_WE_SH = LANE;
    localparam int SU_SH    = COMPACT ? 2 * LANE : 0;
    localparam int SU_WE_SH = COMPACT ? 3 * LANE : LANE;

    logic ctrl_hit;
    logic susp_hit;
    logic su_hit;
    logic unused_wdata;

    // Address match for the two writable words.
    assign ctrl_hit = wr && (addr == ADDR_W'(OFS_CTRL));
    assign susp_hit = wr && (addr == ADDR_W'(OFS_SUSP));
    // Suspend lives in the control word when compact, in its own word otherwise.
    assign su_hit   = COMPACT ? ctrl_hit : susp_hit;
    assign unused_wdata = ^wdata;

    // Per-channel field extraction.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        assign en_wd[i] = wdata[i];
        assign en_we[i] = ctrl_hit & wdata[EN_WE_SH + i];
        assign su_wd[i] = wdata[SU_SH + i];
        assign su_we[i] = su_hit & wdata[SU_WE_SH + i];
    end
endmodule

// File: rtl/chan_ctl_cell.sv
// One channel's state: enable bit, suspend bit and sticky halted flag.
// Assumes write-enables arrive already qualified by the address decode.
module chan_ctl_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic en_we,
    input  logic en_wd,
    input  logic su_we,
    input  logic su_wd,
    input  logic susp_ack,
    output logic en_q,
    output logic su_q,
    output logic sd_q
);
    logic en_d;
    logic su_d;
    logic sd_d;

    // Next state: gated writes, suspend forced low without enable, sticky halt.
    always_comb begin
        en_d = en_we ? en_wd : en_q;
        su_d = en_d & (su_we ? su_wd : su_q);
        sd_d = su_d & (sd_q | (susp_ack & su_q));
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            su_q <= 1'b0;
            sd_q <= 1'b0;
        end else begin
            en_q <= en_d;
            su_q <= su_d;
            sd_q <= sd_d;
        end
    end

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we |=> en_q == $past(en_q)); // R5
    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> en_q == $past(en_wd)); // R12
    AST_SUSP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        su_q |-> en_q); // R9
    AST_HALT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_ack && su_q && !(su_we && !su_wd) && !(en_we && !en_wd)) |=> sd_q); // R10
    AST_HALT_NO_SPONT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_q && !(susp_ack && su_q)) |=> !sd_q); // R10
    AST_HALT_NEEDS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        sd_q |-> su_q); // R11
endmodule

// File: rtl/chan_ctl_rmux.sv
// Read multiplexer: builds the 32-bit read word for the addressed offset.
// Write-enable positions and reserved channel bits are driven 0.
// Assumes 1 <= NUM_CH <= 16.
module chan_ctl_rmux
    import chan_ctl_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] en,
    input  logic [NUM_CH-1:0] su,
    input  logic [NUM_CH-1:0] sd,
    output logic [REG_W-1:0]  rdata
);
    if (NUM_CH <= COMPACT_MAX) begin : g_compact
        // Compact read: enable and suspend share the control word.
        always_comb begin
            rdata = '0;
            if (addr == ADDR_W'(OFS_CTRL)) begin
                rdata[NUM_CH-1:0]  = en;
                rdata[16 +: NUM_CH] = su;
            end else if (addr == ADDR_W'(OFS_STAT)) begin
                rdata[NUM_CH-1:0] = sd;
            end
        end
    end else begin : g_wide
        // Wide read: separate enable and suspend words.
        always_comb begin
            rdata = '0;
            if (addr == ADDR_W'(OFS_CTRL)) begin
                rdata[NUM_CH-1:0] = en;
            end else if (addr == ADDR_W'(OFS_SUSP)) begin
                rdata[NUM_CH-1:0] = su;
            end else if (addr == ADDR_W'(OFS_STAT)) begin
                rdata[NUM_CH-1:0] = sd;
            end
        end
    end
endmodule

// File: rtl/dma_chan_ctl_regs.sv
// Channel enable/suspend register bank with per-bit write-enables and a
// sticky halted status per channel. Layout fixed by NUM_CH (1..16).
// Assumes the register port is single-cycle: writes land at the sampling edge,
// reads are combinational from reg_addr.
module dma_chan_ctl_regs
    import chan_ctl_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NUM_CH-1:0] susp_ack,
    output logic [NUM_CH-1:0] chan_en,
    output logic [NUM_CH-1:0] chan_susp,
    output logic [NUM_CH-1:0] chan_halted
);
    localparam bit          COMPACT = (NUM_CH <= COMPACT_MAX);
    localparam logic [31:0] WE_MASK = COMPACT ? 32'hFF00_FF00 : 32'hFFFF_0000;

    logic [NUM_CH-1:0] en_we;
    logic [NUM_CH-1:0] en_wd;
    logic [NUM_CH-1:0] su_we;
    logic [NUM_CH-1:0] su_wd;

    // Decode register writes into per-channel pairs.
    chan_ctl_wdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_wdec (
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .en_we (en_we),
        .en_wd (en_wd),
        .su_we (su_we),
        .su_wd (su_wd)
    );

    // One state cell per configured channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        chan_ctl_cell i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_we    (en_we[i]),
            .en_wd    (en_wd[i]),
            .su_we    (su_we[i]),
            .su_wd    (su_wd[i]),
            .susp_ack (susp_ack[i]),
            .en_q     (chan_en[i]),
            .su_q     (chan_susp[i]),
            .sd_q     (chan_halted[i])
        );
    end

    // Read path.
    chan_ctl_rmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_rmux (
        .addr  (reg_addr),
        .en    (chan_en),
        .su    (chan_susp),
        .sd    (chan_halted),
        .rdata (reg_rdata)
    );

    AST_WE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_CTRL)) |-> ((reg_rdata & WE_MASK) == 32'h0)); // R6
    AST_STAT_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_STAT)) |-> (reg_rdata[31:16] == 16'h0)); // R8
    AST_COMPACT_NO_SUSP_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (COMPACT && reg_addr == ADDR_W'(OFS_SUSP)) |-> (reg_rdata == 32'h0)); // R7
    AST_HALT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_STAT)) |-> (reg_rdata[NUM_CH-1:0] == chan_halted)); // R10
endmodule

// File: tb/test_dma_chan_ctl_regs.sv
// Bench: a 4-channel (compact) and a 12-channel (wide) instance share one bus.
module test_dma_chan_ctl_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int NX = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [15:0] ack = '0;
    logic [31:0] rdata_c, rdata_x;
    logic [NC-1:0] en_c_o, su_c_o, sd_c_o;
    logic [NX-1:0] en_x_o, su_x_o, sd_x_o;

    logic [15:0] en_c, su_c, sd_c, en_x, su_x, sd_x;
    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    // R2: four channels select the compact layout, twelve the wide layout.
    dma_chan_ctl_regs #(.NUM_CH(NC), .ADDR_W(12)) i_dma_chan_ctl_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_c), .susp_ack(ack[NC-1:0]),
        .chan_en(en_c_o), .chan_susp(su_c_o), .chan_halted(sd_c_o));
    dma_chan_ctl_regs #(.NUM_CH(NX), .ADDR_W(12)) i_dma_chan_ctl_regs_wide (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_x), .susp_ack(ack[NX-1:0]),
        .chan_en(en_x_o), .chan_susp(su_x_o), .chan_halted(sd_x_o));

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Model one clock edge from the requirement text.
    task automatic step(input bit ext, input int n, input logic wr,
                        input logic [11:0] a, input logic [31:0] d,
                        input logic [15:0] k, inout logic [15:0] en,
                        inout logic [15:0] su, inout logic [15:0] sd);
        logic [15:0] m, ew, ev, sw, sv, en_n, su_n;
        m = 16'((32'd1 << n) - 1);
        ew = '0; ev = '0; sw = '0; sv = '0;
        if (wr) begin
            if (!ext && a == 12'h018) begin
                ev = {8'h0, d[7:0]};  ew = {8'h0, d[15:8]};
                sv = {8'h0, d[23:16]}; sw = {8'h0, d[31:24]};
            end
            if (ext && a == 12'h018) begin ev = d[15:0]; ew = d[31:16]; end
            if (ext && a == 12'h020) begin sv = d[15:0]; sw = d[31:16]; end
        end
        ew &= m; sw &= m;
        en_n = ((en & ~ew) | (ev & ew)) & m;
        su_n = ((su & ~sw) | (sv & sw)) & en_n;
        sd = su_n & (sd | (k & su & m));
        en = en_n;
        su = su_n;
    endtask

    function automatic logic [31:0] exp_rd(input bit ext, input logic [11:0] a,
            input logic [15:0] en, input logic [15:0] su, input logic [15:0] sd);
        if (a == 12'h024) return {16'h0, sd};
        if (!ext) begin
            if (a == 12'h018) return {8'h0, su[7:0], 8'h0, en[7:0]};
            return 32'h0;
        end
        if (a == 12'h018) return {16'h0, en};
        if (a == 12'h020) return {16'h0, su};
        return 32'h0;
    endfunction

    task automatic cycle(input logic wr, input logic [11:0] a, input logic [31:0] d,
                         input logic [15:0] k, input string tag);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; ack = k;
        #1;
        chk(tag, "rdata compact", {32'h0, rdata_c}, {32'h0, exp_rd(0, a, en_c, su_c, sd_c)});
        chk(tag, "rdata wide", {32'h0, rdata_x}, {32'h0, exp_rd(1, a, en_x, su_x, sd_x)});
        chk("R12", "outputs compact", {52'h0, sd_c_o, su_c_o, en_c_o},
            {52'h0, sd_c[NC-1:0], su_c[NC-1:0], en_c[NC-1:0]});
        chk("R12", "outputs wide", {28'h0, sd_x_o, su_x_o, en_x_o},
            {28'h0, sd_x[NX-1:0], su_x[NX-1:0], en_x[NX-1:0]});
        @(posedge clk);
        step(0, NC, wr, a, d, k, en_c, su_c, sd_c);
        step(1, NX, wr, a, d, k, en_x, su_x, sd_x);
    endtask

    task automatic read_all(input logic [15:0] k, input string tag);
        cycle(1'b0, 12'h018, 32'h0, k, tag);
        cycle(1'b0, 12'h020, 32'h0, k, tag);
        cycle(1'b0, 12'h024, 32'h0, k, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        en_c = '0; su_c = '0; sd_c = '0; en_x = '0; su_x = '0; sd_x = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        read_all(16'h0, "R1");
        cycle(1'b1, 12'h018, 32'hFF0F_FF0F, 16'h0, "R2");      // R3 compact fields
        read_all(16'h0, "R3");
        cycle(1'b1, 12'h020, 32'h0F0F_0F0F, 16'h0, "R4");      // R7 compact ignores
        read_all(16'h0, "R4/R7");
        cycle(1'b0, 12'h024, 32'h0, 16'hFFFF, "R10");
        cycle(1'b0, 12'h024, 32'h0, 16'h0000, "R10");
        read_all(16'h0, "R10");
        cycle(1'b1, 12'h018, 32'h0200_0000, 16'h0, "R11");     // resume ch1 / disable ch9
        read_all(16'h0, "R11/R9");
        cycle(1'b1, 12'h020, 32'h0002_0000, 16'h0, "R11");     // wide resume ch1
        read_all(16'h0, "R11");
        cycle(1'b1, 12'h018, 32'h0000_0400, 16'h0, "R9");      // compact disable ch2
        read_all(16'h0, "R9/R5");
        cycle(1'b1, 12'h018, 32'hFFFF_FFFF, 16'h0, "R8");
        read_all(16'h0, "R6/R8");
        cycle(1'b1, 12'h020, 32'hFFFF_FFFF, 16'h0, "R8");
        read_all(16'hFFFF, "R8/R10");
        cycle(1'b1, 12'h018, 32'h0, 16'h0, "R5");
        cycle(1'b1, 12'h030, 32'hFFFF_FFFF, 16'h0, "R5");
        read_all(16'h0, "R5");
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            case (lfsr[1:0])
                2'd0: a = 12'h018;
                2'd1: a = 12'h020;
                2'd2: a = 12'h024;
                default: a = 12'h01C;
            endcase
            cycle(lfsr[2], a, {lfsr[31:16] ^ lfsr[15:0], lfsr[15:0] ^ {lfsr[7:0], lfsr[31:24]}},
                  lfsr[27:12], "R5");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule